// File: doc/BRIEF.md
# Prescaled Seconds Counter

This peripheral keeps elapsed time as a 32-bit count that advances once per programmable time quantum. An input tick strobe, one clock cycle wide, drives a 20-bit down-counting divider. Each time the divider expires, the count advances by one. A 32-bit match value can raise an alarm, and three event flags (quantum, alarm, wrap) can each be routed to one interrupt line through their own enables.

Software reaches all state through 16-bit registers on a small synchronous register bus. The reload, count and match values can only be changed inside a configuration window. Values written during that window wait in shadow storage. They are committed together when the window is closed. An idle bit tells software when that commit has finished. A sync bit tells it when the readable state has caught up with the tick domain.

Top module: `quantum_rtc`

## Requirements
- R1: After reset the count is 0, the reload and divider are 0, the match value is 0xFFFFFFFF, all flags and enables are 0, the sync bit is 0 and the idle bit is 1. Register 0 therefore reads 0x0020 and `irq` is 0.
- R2: A write to registers 2 to 7 while the configuration bit (register 0 bit 4) is 0 is ignored. Reading back the written register shows its previous value.
- R3: When register 0 is written with bit 4 cleared while it was set, the idle bit (register 0 bit 5) reads 0 for exactly 3 consecutive cycles. After that, every half written during the window holds its new value, and the divider restarts from the new reload value if a reload half was written.
- R4: On each tick the divider counts down, and on a tick that finds it at 0 it reloads instead. That reloading tick advances the count by one, so one quantum is reload+1 ticks. The divider reads back at registers 8 (bits 19:16 in bits 3:0) and 9 (bits 15:0).
- R5: Every quantum sets the quantum flag (register 0 bit 0).
- R6: A quantum that takes the count from 0xFFFFFFFF to 0 sets the wrap flag (register 0 bit 2).
- R7: A quantum after which the count equals the match value sets the alarm flag (register 0 bit 1).
- R8: Writing 0 to a flag bit of register 0 clears that flag and writing 1 leaves it unchanged. No configuration window is needed for this. If a flag is set by hardware in the same cycle as a clear, the flag ends up set.
- R9: `irq` is registered. It is 1 in the cycle after any flag whose enable in register 1 (bit 0 quantum, bit 1 alarm, bit 2 wrap) is set was 1, and 0 otherwise. The enables can be written at any time.
- R10: Writing 0 to register 0 bit 3 clears the sync bit, and a commit clears it as well. The bit is set again on the second tick counted after that, outside a commit.
- R11: The register map is: 0 status/control, 1 interrupt enables, 2/3 reload high (bits 19:16)/low, 4/5 count high/low, 6/7 match high/low, 8/9 divider high/low. Read data appears on `bus_rdata` one cycle after a selected read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle time-base strobe |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register index |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can meet in one cycle. In the first, a quantum can set a flag in the same cycle that software writes 0 to clear it. The bench drives a tick with reload 0 together with a clearing write to register 0, and expects the quantum flag set and the count advanced. A clearing write without a tick must leave the flag clear. In the second, the wrap and alarm flags can be raised by the same increment. A count of 0xFFFFFFFF with a match of 0 must raise both flags on one tick. Random runs also place counts close to wrap, with match values close ahead, so the bench functions must resolve both flags over many increments.

// File: rtl/qrtc_pkg.sv
package qrtc_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_STAT    = 4'd0;
  localparam logic [ADDR_W-1:0] A_IEN     = 4'd1;
  localparam logic [ADDR_W-1:0] A_HALF0   = 4'd2;
  localparam logic [ADDR_W-1:0] A_DIV_HI  = 4'd8;
  localparam logic [ADDR_W-1:0] A_DIV_LO  = 4'd9;

  localparam int NHALF = 6;
  localparam int H_RL_HI  = 0;
  localparam int H_RL_LO  = 1;
  localparam int H_CNT_HI = 2;
  localparam int H_CNT_LO = 3;
  localparam int H_MT_HI  = 4;
  localparam int H_MT_LO  = 5;

  localparam int B_QF   = 0;
  localparam int B_AF   = 1;
  localparam int B_WF   = 2;
  localparam int B_SYNC = 3;
  localparam int B_CFG  = 4;
  localparam int B_IDLE = 5;
endpackage

// File: rtl/qrtc_prescaler.sv
module qrtc_prescaler #(
  parameter int PRE_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [PRE_W-1:0] load_val,
  input  logic [PRE_W-1:0] reload,
  output logic [PRE_W-1:0] div_q,
  output logic             quantum
);
  // a commit load takes priority over the tick of the same cycle
  assign quantum = tick && (div_q == '0) && !load;

  always_ff @(posedge clk) begin
    if (rst)       div_q <= '0;
    else if (load) div_q <= load_val;
    else if (tick) div_q <= (div_q == '0) ? reload : div_q - PRE_W'(1);
  end
endmodule

// File: rtl/qrtc_commit.sv
module qrtc_commit #(
  parameter int REG_W      = 16,
  parameter int NH         = 6,
  parameter int COMMIT_CYC = 3,
  parameter int SYNC_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NH-1:0]     hw_wr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              start,
  input  logic              tick,
  input  logic              sync_clr,
  output logic [NH*REG_W-1:0] shadow,
  output logic [NH-1:0]     pend,
  output logic              commit,
  output logic              busy,
  output logic              sync
);
  localparam int BW = $clog2(COMMIT_CYC + 1);
  localparam int SW = $clog2(SYNC_TICKS + 1);

  logic [BW-1:0] busy_cnt;
  logic [SW-1:0] sync_cnt;

  assign busy   = (busy_cnt != '0);
  assign commit = (busy_cnt == BW'(1));

  for (genvar h = 0; h < NH; h++) begin : g_half
    always_ff @(posedge clk) begin
      if (hw_wr[h]) shadow[h*REG_W +: REG_W] <= wdata;
    end
    always_ff @(posedge clk) begin
      if (rst)            pend[h] <= 1'b0;
      else if (commit)    pend[h] <= 1'b0;
      else if (hw_wr[h])  pend[h] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        busy_cnt <= '0;
    else if (start) busy_cnt <= BW'(COMMIT_CYC);
    else if (busy)  busy_cnt <= busy_cnt - BW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || commit || sync_clr) begin
      sync     <= 1'b0;
      sync_cnt <= '0;
    end else if (!sync && !busy && tick) begin
      if (sync_cnt == SW'(SYNC_TICKS - 1)) sync <= 1'b1;
      else                                 sync_cnt <= sync_cnt + SW'(1);
    end
  end
endmodule

// File: rtl/quantum_rtc.sv
module quantum_rtc
  import qrtc_pkg::*;
#(
  parameter int REG_W      = 16,
  parameter int PRE_W      = 20,
  parameter int COMMIT_CYC = 3,
  parameter int SYNC_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [3:0]       bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  output logic             irq
);
  localparam int CNT_W    = 2 * REG_W;
  localparam int PRE_HI_W = PRE_W - REG_W;

  logic             wr, wr_stat, cfg_en, cfg_close;
  logic [NHALF-1:0] hw_wr, pend;
  logic [NHALF*REG_W-1:0] shadow;
  logic             commit, busy, sync;
  logic [PRE_W-1:0] reload_q, reload_nx, div_q;
  logic [CNT_W-1:0] cnt_q, cnt_nx, match_q, match_nx;
  logic             quantum, rl_load, cnt_load, mt_load;
  logic             qf, af, wf, wrap_hit, match_hit;
  logic [2:0]       ien;
  logic             unused_hi_bits;

  assign wr        = bus_sel && bus_we;
  assign wr_stat   = wr && (bus_addr == A_STAT);
  assign cfg_close = wr_stat && cfg_en && !bus_wdata[B_CFG] && !busy;

  for (genvar h = 0; h < NHALF; h++) begin : g_wr
    assign hw_wr[h] = wr && cfg_en && (bus_addr == A_HALF0 + 4'(h));
  end

  qrtc_commit #(.REG_W(REG_W), .NH(NHALF), .COMMIT_CYC(COMMIT_CYC),
                .SYNC_TICKS(SYNC_TICKS)) u_commit (
    .clk(clk), .rst(rst), .hw_wr(hw_wr), .wdata(bus_wdata), .start(cfg_close),
    .tick(tick), .sync_clr(wr_stat && !bus_wdata[B_SYNC]),
    .shadow(shadow), .pend(pend), .commit(commit), .busy(busy), .sync(sync));

  assign unused_hi_bits = ^shadow[H_RL_HI*REG_W + PRE_HI_W +: (REG_W - PRE_HI_W)];

  assign rl_load  = commit && (pend[H_RL_HI] || pend[H_RL_LO]);
  assign cnt_load = commit && (pend[H_CNT_HI] || pend[H_CNT_LO]);
  assign mt_load  = commit && (pend[H_MT_HI] || pend[H_MT_LO]);

  assign reload_nx = {pend[H_RL_HI] ? shadow[H_RL_HI*REG_W +: PRE_HI_W] : reload_q[PRE_W-1:REG_W],
                      pend[H_RL_LO] ? shadow[H_RL_LO*REG_W +: REG_W]    : reload_q[REG_W-1:0]};
  assign cnt_nx    = {pend[H_CNT_HI] ? shadow[H_CNT_HI*REG_W +: REG_W] : cnt_q[CNT_W-1:REG_W],
                      pend[H_CNT_LO] ? shadow[H_CNT_LO*REG_W +: REG_W] : cnt_q[REG_W-1:0]};
  assign match_nx  = {pend[H_MT_HI] ? shadow[H_MT_HI*REG_W +: REG_W] : match_q[CNT_W-1:REG_W],
                      pend[H_MT_LO] ? shadow[H_MT_LO*REG_W +: REG_W] : match_q[REG_W-1:0]};

  qrtc_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .tick(tick), .load(rl_load), .load_val(reload_nx),
    .reload(reload_q), .div_q(div_q), .quantum(quantum));

  assign wrap_hit  = quantum && !cnt_load && (cnt_q == '1);
  assign match_hit = quantum && !cnt_load && ((cnt_q + CNT_W'(1)) == match_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '0;
      cnt_q    <= '0;
      match_q  <= '1;
    end else begin
      if (rl_load)       reload_q <= reload_nx;
      if (cnt_load)      cnt_q    <= cnt_nx;
      else if (quantum)  cnt_q    <= cnt_q + CNT_W'(1);
      if (mt_load)       match_q  <= match_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_en <= 1'b0;
      ien    <= '0;
      qf     <= 1'b0;
      af     <= 1'b0;
      wf     <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (wr_stat && !busy)                   cfg_en <= bus_wdata[B_CFG];
      if (wr && (bus_addr == A_IEN))          ien    <= bus_wdata[2:0];
      if (quantum)                            qf <= 1'b1;
      else if (wr_stat && !bus_wdata[B_QF])   qf <= 1'b0;
      if (match_hit)                          af <= 1'b1;
      else if (wr_stat && !bus_wdata[B_AF])   af <= 1'b0;
      if (wrap_hit)                           wf <= 1'b1;
      else if (wr_stat && !bus_wdata[B_WF])   wf <= 1'b0;
      irq <= |({wf, af, qf} & ien);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_sel && !bus_we) begin
      bus_rdata <= '0;
      case (bus_addr)
        A_STAT: begin
          bus_rdata[B_QF]   <= qf;
          bus_rdata[B_AF]   <= af;
          bus_rdata[B_WF]   <= wf;
          bus_rdata[B_SYNC] <= sync;
          bus_rdata[B_CFG]  <= cfg_en;
          bus_rdata[B_IDLE] <= !busy;
        end
        A_IEN:    bus_rdata <= REG_W'(ien);
        4'd2:     bus_rdata <= REG_W'(reload_q[PRE_W-1:REG_W]);
        4'd3:     bus_rdata <= reload_q[REG_W-1:0];
        4'd4:     bus_rdata <= cnt_q[CNT_W-1:REG_W];
        4'd5:     bus_rdata <= cnt_q[REG_W-1:0];
        4'd6:     bus_rdata <= match_q[CNT_W-1:REG_W];
        4'd7:     bus_rdata <= match_q[REG_W-1:0];
        A_DIV_HI: bus_rdata <= REG_W'(div_q[PRE_W-1:REG_W]);
        A_DIV_LO: bus_rdata <= div_q[REG_W-1:0];
        default:  bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/qrtc_checker.sv
module qrtc_checker #(
  parameter int PRE_W      = 20,
  parameter int CNT_W      = 32,
  parameter int COMMIT_CYC = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             commit,
  input logic             quantum,
  input logic             cnt_load,
  input logic             sync,
  input logic             qf,
  input logic             wf,
  input logic [PRE_W-1:0] div_q,
  input logic [PRE_W-1:0] reload_q,
  input logic [CNT_W-1:0] cnt_q
);
  logic [7:0] busy_run;

  always_ff @(posedge clk) begin
    if (rst || !busy) busy_run <= '0;
    else              busy_run <= busy_run + 8'd1;
  end

  // R3: commit window lasts exactly COMMIT_CYC cycles
  a_r3_commit_len: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_run == 8'(COMMIT_CYC)));

  a_r3_idle_after_commit: assert property (@(posedge clk) disable iff (rst)
    commit |=> !busy);

  a_r4_div_in_range: assert property (@(posedge clk) disable iff (rst)
    div_q <= reload_q);

  a_r4_count_step: assert property (@(posedge clk) disable iff (rst)
    (quantum && !cnt_load) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  a_r2_count_hold: assert property (@(posedge clk) disable iff (rst)
    (!quantum && !cnt_load) |=> $stable(cnt_q));

  a_r5_quantum_flag: assert property (@(posedge clk) disable iff (rst)
    quantum |=> qf);

  a_r6_wrap_flag: assert property (@(posedge clk) disable iff (rst)
    (quantum && !cnt_load && (cnt_q == '1)) |=> (wf && (cnt_q == '0)));

  a_r10_sync_drop: assert property (@(posedge clk) disable iff (rst)
    commit |=> !sync);
endmodule

bind quantum_rtc qrtc_checker #(.PRE_W(PRE_W), .CNT_W(CNT_W), .COMMIT_CYC(COMMIT_CYC)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .commit(commit), .quantum(quantum),
  .cnt_load(cnt_load), .sync(sync), .qf(qf), .wf(wf), .div_q(div_q),
  .reload_q(reload_q), .cnt_q(cnt_q));

// File: tb/quantum_rtc_bench.sv
module quantum_rtc_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;

  int vectors = 0;
  int misses = 0;
  bit done = 0;

  always #10 clk = ~clk;

  quantum_rtc u_quantum_rtc (
    .clk(clk), .rst(rst), .tick(tick), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      misses++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); d = bus_rdata; bus_sel = 0;
  endtask

  task automatic rd32(input logic [3:0] a_hi, output logic [31:0] v);
    logic [15:0] h, l;
    rd(a_hi, h); rd(a_hi + 4'd1, l);
    v = {h, l};
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic wait_idle();
    logic [15:0] v;
    do rd(4'd0, v); while (!v[5]);
  endtask

  task automatic configure(input logic [19:0] r, input logic [31:0] c, input logic [31:0] m);
    wait_idle();
    wr(4'd0, 16'h001F);
    wr(4'd2, {12'h0, r[19:16]}); wr(4'd3, r[15:0]);
    wr(4'd4, c[31:16]);          wr(4'd5, c[15:0]);
    wr(4'd6, m[31:16]);          wr(4'd7, m[15:0]);
    wr(4'd0, 16'h000F);
    wait_idle();
  endtask

  function automatic logic [2:0] exp_flags(input logic [31:0] c, input logic [31:0] m, input int k);
    logic [32:0] sum;
    logic [31:0] d;
    sum = {1'b0, c} + 33'(k);
    d = m - c;
    exp_flags[0] = (k > 0);
    exp_flags[1] = (d != 0) && (d <= 32'(k));
    exp_flags[2] = sum[32];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    logic [31:0] w;
    int zeros, seed;
    seed = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    rd(4'd0, v);  chk("R1 status", 32'(v), 32'h20);
    rd32(4'd6, w); chk("R1 match", w, 32'hFFFFFFFF);
    rd32(4'd4, w); chk("R1 count", w, 32'h0);
    rd32(4'd2, w); chk("R1 reload", w, 32'h0);
    rd32(4'd8, w); chk("R1 divider", w, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);

    // R10 sync after two ticks; R4 reload 0 counts each tick
    ticks(1); rd(4'd0, v); chk("R10 sync after 1 tick", 32'(v[3]), 0);
    ticks(1); rd(4'd0, v); chk("R10 sync after 2 ticks", 32'(v[3]), 1);
    rd32(4'd4, w); chk("R4 count reload0", w, 32'd2);
    chk("R5 quantum flag", 32'(v[0]), 1);
    wr(4'd0, 16'h0017); rd(4'd0, v); chk("R10 sync cleared", 32'(v[3]), 0);

    // R8 writing 1 keeps, writing 0 clears
    wr(4'd0, 16'h000F); rd(4'd0, v); chk("R8 write-1 keeps", 32'(v[0]), 1);
    wr(4'd0, 16'h0008); rd(4'd0, v); chk("R8 write-0 clears", 32'(v[0]), 0);

    // R2 writes outside configuration ignored
    wr(4'd5, 16'h1234); wr(4'd3, 16'h0055); wr(4'd7, 16'h0);
    rd(4'd5, v); chk("R2 count ignored", 32'(v), 32'd2);
    rd(4'd3, v); chk("R2 reload ignored", 32'(v), 0);
    rd(4'd7, v); chk("R2 match ignored", 32'(v), 32'hFFFF);

    // R3 idle low exactly 3 cycles, R11 read latency
    wr(4'd0, 16'h001F);
    wr(4'd3, 16'h0004); wr(4'd5, 16'h0100);
    wr(4'd0, 16'h000F);
    bus_sel = 1; bus_we = 0; bus_addr = 4'd0;
    zeros = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!bus_rdata[5]) zeros++;
    end
    bus_sel = 0;
    chk("R3 idle low cycles", 32'(zeros), 3);
    rd32(4'd4, w); chk("R3 count committed", w, 32'h100);
    rd32(4'd8, w); chk("R3 divider restarted", w, 32'd4);

    // R8 set wins over simultaneous clear
    configure(20'd0, 32'd5, 32'hFFFFFFFF);
    wr(4'd0, 16'h0008);
    @(negedge clk); tick = 1; bus_sel = 1; bus_we = 1; bus_addr = 4'd0; bus_wdata = 16'h0008;
    @(negedge clk); tick = 0; bus_sel = 0; bus_we = 0;
    rd(4'd0, v);  chk("R8 set beats clear", 32'(v[0]), 1);
    rd32(4'd4, w); chk("R4 count with clear", w, 32'd6);
    wr(4'd0, 16'h0008); rd(4'd0, v); chk("R8 clear alone", 32'(v[0]), 0);

    // R6 and R7 on the same increment
    configure(20'd0, 32'hFFFFFFFF, 32'd0);
    wr(4'd0, 16'h0008);
    ticks(1);
    rd(4'd0, v);  chk("R6 R7 wrap and alarm", 32'(v[2:0]), 32'h7);
    rd32(4'd4, w); chk("R6 count wrapped", w, 32'd0);

    // R9 interrupt enables
    wr(4'd1, 16'h0004); @(negedge clk); chk("R9 irq wrap enabled", 32'(irq), 1);
    wr(4'd1, 16'h0000); @(negedge clk); chk("R9 irq disabled", 32'(irq), 0);
    wr(4'd1, 16'h0002); wr(4'd0, 16'h000D); @(negedge clk);
    chk("R9 irq after alarm clear", 32'(irq), 0);
    wr(4'd1, 16'h0000);

    // random configurations
    for (int it = 0; it < 30; it++) begin
      logic [19:0] r;
      logic [31:0] c, m, ecnt;
      logic [2:0] ie, fl;
      int n, k;
      r = ($urandom % 5 == 0) ? (20'h10000 | 20'($urandom % 4)) : 20'($urandom % 4);
      c = ($urandom % 2) ? $urandom : (32'hFFFFFFFF - 32'($urandom % 8));
      m = c + 32'($urandom % 12);
      n = $urandom % 30;
      ie = 3'($urandom);
      configure(r, c, m);
      wr(4'd0, 16'h0008);
      wr(4'd1, {13'h0, ie});
      ticks(n);
      k = n / (int'(r) + 1);
      ecnt = c + 32'(k);
      fl = exp_flags(c, m, k);
      rd32(4'd4, w); chk("R4 random count", w, ecnt);
      rd32(4'd8, w); chk("R4 random divider", w, 32'(r) - 32'(n % (int'(r) + 1)));
      rd(4'd0, v);
      chk("R5 R6 R7 random flags", 32'(v[2:0]), 32'(fl));
      chk("R10 random sync", 32'(v[3]), 32'(n >= 2));
      chk("R9 random irq", 32'(irq), 32'(|(fl & ie)));
    end

    finish_run();
  end
endmodule